// File: doc/BRIEF.md
# Cascaded Interval Timer

This block is a small timer built from two 8-bit counters in series. The first counter advances on ticks of a slow auxiliary clock or of a fast main clock. The second counter advances on one of three sources: the slow clock, every wrap of the first counter (the slow clock divided by 256), or the fast clock. A selectable carry tap on the second counter sets a sticky interval flag. That flag can be masked onto an interrupt request. An independent tap on the first counter produces a one-cycle frame strobe for a display driver.

Everything runs on one system clock. The two time bases arrive as single-cycle tick enables, so the block contains no clock multiplexing. Software sees four byte registers on a simple write/read bus: a control byte, a status byte holding the flag and its mask, and the two count values at consecutive addresses.

Top module: `cascade_tick_timer`

## Requirements
- R1: After a synchronous active-low reset, the control byte, the status byte and both counters read 0x00. The strobe and interrupt outputs are low.
- R2: Address 0 holds the control byte and address 1 the status byte (bit 0 flag, bit 1 interrupt enable). Addresses 2 and 3 hold the first and second count. Every written value reads back unchanged through `bus_rdata`.
- R3: The first counter increments once per `slow_tick` when control bit 7 is 0, and once per `fast_tick` when control bit 7 is 1.
- R4: The second counter source is selected by control bits 7 and 5. With both clear it uses `slow_tick`. With bit 5 set and bit 7 clear it uses each wrap of the first counter from 0xFF to 0x00. With bit 7 set it uses `fast_tick`.
- R5: With interval code n in control bits 2:0, the flag is set once every 2^(n+1) increments of the second counter. This happens when the increment carries out of bit n.
- R6: With frame code m in control bits 4:3, `lcd_strobe` pulses high for exactly one cycle once every 2^(m+5) increments of the first counter. This happens when the increment carries out of bit m+4.
- R7: While control bit 6 (hold) is set, the first counter does not change except by a bus write. With bit 5 clear, the second counter keeps counting.
- R8: While control bits 6 and 5 are both set, neither counter changes except by a bus write.
- R9: The flag stays set until software writes address 1 with bit 0 equal to 0. A write with bit 0 equal to 1 leaves it set.
- R10: `irq` is high exactly when the flag and the enable bit are both set.
- R11: A bus write to a count register wins over an increment in the same cycle. The written value appears on the next cycle, and counting resumes from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable for the slow auxiliary time base |
| fast_tick | input | 1 | One-cycle enable for the fast main time base |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| lcd_strobe | output | 1 | One-cycle frame-rate pulse |
| irq_flag | output | 1 | Sticky interval flag |
| irq | output | 1 | Flag gated by the enable bit |

## Verification
The properties assume that the tick inputs are single-cycle enables sampled on the system clock. They also assume that the frame strobe cannot recur on consecutive cycles, because its shortest period is 32 counter increments. The stimulus drives `fast_tick` at most once per cycle and `slow_tick` once every four cycles, both from a generator tied to the falling clock edge. Bus writes are single-cycle pulses. Periods are measured only after two events under a stable configuration, so a partial period left from a mode change never enters a comparison.

// File: rtl/ctt_pkg.sv
// Shared constants and the control-byte layout for the cascaded interval timer.
package ctt_pkg;
    localparam int BYTE_W       = 8;
    localparam int CNT_W        = 8;
    localparam int ADDR_W       = 2;
    localparam int IVL_SEL_W    = 3;
    localparam int LCD_SEL_W    = 2;
    localparam int IVL_TAP_BASE = 0;
    localparam int LCD_TAP_BASE = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 2'd0,
        A_STAT   = 2'd1,
        A_CNT_LO = 2'd2,
        A_CNT_HI = 2'd3
    } addr_e;

    // Control byte, MSB first: source, hold, divide, frame code, interval code.
    typedef struct packed {
        logic                 src_fast;
        logic                 hold;
        logic                 div_sel;
        logic [LCD_SEL_W-1:0] lcd_sel;
        logic [IVL_SEL_W-1:0] ivl_sel;
    } ctrl_t;
endpackage

// File: rtl/ctt_stage.sv
// One counter stage with a bus load port and a selectable carry tap.
// wrap fires when an increment rolls the whole counter over. tap_evt fires
// when an increment carries out of bit BASE+sel. A load suppresses both.
// Assumes inc and load are single-cycle qualifiers on the system clock.
module ctt_stage #(
    parameter int W     = 8,
    parameter int SEL_W = 3,
    parameter int BASE  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     load_val,
    input  logic             inc,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     count,
    output logic             wrap,
    output logic             tap_evt
);
    logic low_ones;
    logic step;

    assign step = inc && !load;

    // Counter register: a load beats an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (load)  count <= load_val;
        else if (inc)   count <= count + 1'b1;
    end

    // Check that every bit up to the tapped position is one.
    always_comb begin
        low_ones = 1'b1;
        for (int i = 0; i < W; i++) begin
            if (i <= BASE + int'(sel)) low_ones = low_ones & count[i];
        end
    end

    // Carry events derived from the current count and the step.
    assign wrap    = step && (&count);
    assign tap_evt = step && low_ones;
endmodule

// File: rtl/ctt_regs.sv
// Register file: control byte, sticky flag with its enable, and read mux.
// Count registers live in the stages; this block only decodes their writes.
// Assumes bus_wr is a single-cycle strobe; reads are combinational.
module ctt_regs import ctt_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_lo,
    input  logic [CNT_W-1:0]  cnt_hi,
    input  logic              ivl_evt,
    output ctrl_t             ctrl,
    output logic              flag,
    output logic              irq_en,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic [BYTE_W-1:0] rdata
);
    logic wr_ctrl;
    logic wr_stat;

    // Address decode for writes.
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign wr_lo   = bus_wr && (bus_addr == A_CNT_LO);
    assign wr_hi   = bus_wr && (bus_addr == A_CNT_HI);

    // Control byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata);
    end

    // Interrupt enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_en <= 1'b0;
        else if (wr_stat) irq_en <= bus_wdata[1];
    end

    // Sticky flag: a new event wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                        flag <= 1'b0;
        else if (ivl_evt)                  flag <= 1'b1;
        else if (wr_stat && !bus_wdata[0]) flag <= 1'b0;
    end

    // Read mux.
    always_comb begin
        unique case (bus_addr)
            A_CTRL:   rdata = BYTE_W'(ctrl);
            A_STAT:   rdata = {{(BYTE_W-2){1'b0}}, irq_en, flag};
            A_CNT_LO: rdata = cnt_lo;
            default:  rdata = cnt_hi;
        endcase
    end
endmodule

// File: rtl/cascade_tick_timer.sv
// Top level of the cascaded interval timer.
// Picks the increment sources for both stages, applies hold, registers the
// frame strobe and gates the interrupt. Assumes slow_tick and fast_tick are
// single-cycle enables in the clk domain.
module cascade_tick_timer import ctt_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              lcd_strobe,
    output logic              irq_flag,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic              irq_en;
    logic              wr_lo, wr_hi;
    logic [CNT_W-1:0]  cnt1_q, cnt2_q;
    logic              inc1, inc2, src2;
    logic              wrap1, wrap2;
    logic              lcd_evt, ivl_evt;

    // First stage source and hold gating.
    assign inc1 = (ctrl_q.src_fast ? fast_tick : slow_tick) && !ctrl_q.hold;

    // Second stage source: fast, first-stage wrap, or slow.
    assign src2 = ctrl_q.src_fast ? fast_tick
                : (ctrl_q.div_sel ? wrap1 : slow_tick);
    assign inc2 = src2 && !(ctrl_q.hold && ctrl_q.div_sel);

    ctt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_lo    (cnt1_q),
        .cnt_hi    (cnt2_q),
        .ivl_evt   (ivl_evt),
        .ctrl      (ctrl_q),
        .flag      (irq_flag),
        .irq_en    (irq_en),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .rdata     (bus_rdata)
    );

    ctt_stage #(.W(CNT_W), .SEL_W(LCD_SEL_W), .BASE(LCD_TAP_BASE)) u_stage1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_lo),
        .load_val (bus_wdata),
        .inc      (inc1),
        .sel      (ctrl_q.lcd_sel),
        .count    (cnt1_q),
        .wrap     (wrap1),
        .tap_evt  (lcd_evt)
    );

    ctt_stage #(.W(CNT_W), .SEL_W(IVL_SEL_W), .BASE(IVL_TAP_BASE)) u_stage2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_hi),
        .load_val (bus_wdata),
        .inc      (inc2),
        .sel      (ctrl_q.ivl_sel),
        .count    (cnt2_q),
        .wrap     (wrap2),
        .tap_evt  (ivl_evt)
    );

    // Frame strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n) lcd_strobe <= 1'b0;
        else        lcd_strobe <= lcd_evt;
    end

    // Masked interrupt request.
    assign irq = irq_flag && irq_en;

    logic unused_wrap2;
    assign unused_wrap2 = wrap2;
endmodule

// File: rtl/ctt_checker.sv
// Temporal checks for cascade_tick_timer, bound onto every instance.
module ctt_checker import ctt_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] ctrl_b,
    input logic [CNT_W-1:0]  cnt1,
    input logic [CNT_W-1:0]  cnt2,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              lcd_strobe,
    input logic              irq_flag,
    input logic              irq
);
    // R7
    hold_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_b[6] && !(bus_wr && bus_addr == A_CNT_LO)) |=> $stable(cnt1));

    // R8
    hold_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_b[6] && ctrl_b[5] && !(bus_wr && bus_addr == A_CNT_HI)) |=> $stable(cnt2));

    // R6
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_strobe |=> !lcd_strobe);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !(bus_wr && bus_addr == A_STAT && !bus_wdata[0])) |=> irq_flag);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_flag);

    // R11
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CNT_LO) |=> (cnt1 == $past(bus_wdata)));
endmodule

bind cascade_tick_timer ctt_checker u_ctt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_b     (ctrl_q),
    .cnt1       (cnt1_q),
    .cnt2       (cnt2_q),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .lcd_strobe (lcd_strobe),
    .irq_flag   (irq_flag),
    .irq        (irq)
);

// File: tb/cascade_tick_timer_bench.sv
module cascade_tick_timer_bench;
    localparam int SLOW_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       fast_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       lcd_strobe, irq_flag, irq;

    int  n_run = 0;
    int  n_fail = 0;
    bit  tick_on = 1'b0;
    int  cyc = 0;
    int  lcd_cnt = 0, lcd_last = 0, lcd_prev = 0;
    int  irq_cnt = 0, irq_last = 0;
    bit  flag_prev = 1'b0;

    always #2 clk = ~clk;

    cascade_tick_timer u_cascade_tick_timer (
        .clk (clk), .rst_n (rst_n), .slow_tick (slow_tick), .fast_tick (fast_tick),
        .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .lcd_strobe (lcd_strobe), .irq_flag (irq_flag), .irq (irq)
    );

    // Tick generator: fast every cycle, slow every SLOW_DIV cycles.
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            fast_tick = tick_on;
            slow_tick = tick_on && (ph == 0);
            ph = (ph + 1) % SLOW_DIV;
        end
    end

    // Event monitor: time stamps of strobes and flag rises.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (lcd_strobe) begin lcd_prev = lcd_last; lcd_last = cyc; lcd_cnt++; end
            if (irq_flag && !flag_prev) begin irq_last = cyc; irq_cnt++; end
            flag_prev = irq_flag;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic measure_lcd(output int d);
        int c0 = lcd_cnt;
        while (lcd_cnt < c0 + 3) @(negedge clk);
        d = lcd_last - lcd_prev;
    endtask

    task automatic measure_irq(output int d);
        int c0, t1;
        wr(2'd1, 8'h00);
        c0 = irq_cnt;
        while (irq_cnt == c0) @(negedge clk);
        t1 = irq_last;
        wr(2'd1, 8'h00);
        c0 = irq_cnt;
        while (irq_cnt == c0) @(negedge clk);
        d = irq_last - t1;
    endtask

    // R1: reset values at the ports.
    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == 8'h00, "R1", v, 0);
        end
        check(!lcd_strobe && !irq, "R1", {lcd_strobe, irq}, 0);
    endtask

    // R2: register read-back.
    task automatic t_readback;
        logic [7:0] v;
        wr(2'd0, 8'h1D); rd(2'd0, v); check(v == 8'h1D, "R2 ctrl", v, 8'h1D);
        wr(2'd2, 8'h5A); rd(2'd2, v); check(v == 8'h5A, "R2 cnt lo", v, 8'h5A);
        wr(2'd3, 8'hC3); rd(2'd3, v); check(v == 8'hC3, "R2 cnt hi", v, 8'hC3);
        wr(2'd1, 8'h02); rd(2'd1, v); check(v == 8'h02, "R2 status", v, 8'h02);
        wr(2'd1, 8'h00); wr(2'd0, 8'h00);
    endtask

    // R3: first counter rate for both sources.
    task automatic t_rate;
        logic [7:0] a, b;
        wr(2'd0, 8'h00);
        rd(2'd2, a); repeat (199) @(negedge clk); rd(2'd2, b);
        check(8'(b - a) == 8'd50, "R3 slow", 8'(b - a), 50);
        wr(2'd0, 8'h80);
        rd(2'd2, a); repeat (99) @(negedge clk); rd(2'd2, b);
        check(8'(b - a) == 8'd100, "R3 fast", 8'(b - a), 100);
    endtask

    // R5 and R4: every interval code on the slow source, then wrap and fast sources.
    task automatic t_interval;
        int d;
        for (int n = 0; n < 8; n++) begin
            wr(2'd0, 8'(n));
            measure_irq(d);
            check(d == (2 << n) * SLOW_DIV, "R5 interval", d, (2 << n) * SLOW_DIV);
        end
        wr(2'd0, 8'h20);
        measure_irq(d);
        check(d == 512 * SLOW_DIV, "R4 wrap source", d, 512 * SLOW_DIV);
        wr(2'd0, 8'h82);
        measure_irq(d);
        check(d == 8, "R4 fast source", d, 8);
    endtask

    // R6: every frame code on the slow source, one on the fast source.
    task automatic t_lcd;
        int d;
        for (int m = 0; m < 4; m++) begin
            wr(2'd0, 8'(m << 3));
            measure_lcd(d);
            check(d == (32 << m) * SLOW_DIV, "R6 frame", d, (32 << m) * SLOW_DIV);
        end
        wr(2'd0, 8'h80);
        measure_lcd(d);
        check(d == 32, "R6 frame fast", d, 32);
    endtask

    // R7 and R8: hold behaviour.
    task automatic t_hold;
        logic [7:0] a1, a2, b1, b2;
        wr(2'd0, 8'h40);
        rd(2'd2, a1); rd(2'd3, a2); repeat (199) @(negedge clk); rd(2'd2, b1); rd(2'd3, b2);
        check(a1 == b1, "R7 first frozen", b1, a1);
        check(8'(b2 - a2) == 8'd50, "R7 second runs", 8'(b2 - a2), 50);
        wr(2'd0, 8'h60);
        rd(2'd2, a1); rd(2'd3, a2); repeat (199) @(negedge clk); rd(2'd2, b1); rd(2'd3, b2);
        check(a1 == b1, "R8 first frozen", b1, a1);
        check(a2 == b2, "R8 second frozen", b2, a2);
    endtask

    // R11: write beats a same-cycle increment.
    task automatic t_priority;
        logic [7:0] v;
        wr(2'd0, 8'h80);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h40;
        @(negedge clk);
        bus_wr = 1'b0;
        #1 v = bus_rdata;
        check(v == 8'h40, "R11 load", v, 8'h40);
        @(negedge clk); #1 v = bus_rdata;
        check(v == 8'h41, "R11 resume", v, 8'h41);
    endtask

    // R9 and R10: sticky flag and interrupt gating with ticks stopped.
    task automatic t_flag;
        logic [7:0] v;
        wr(2'd0, 8'h80);
        repeat (10) @(negedge clk);
        tick_on = 1'b0;
        repeat (3) @(negedge clk);
        check(irq_flag == 1'b1, "R9 set", irq_flag, 1);
        check(irq == 1'b0, "R10 masked", irq, 0);
        wr(2'd1, 8'h03);
        @(negedge clk);
        check(irq_flag == 1'b1, "R9 keep", irq_flag, 1);
        check(irq == 1'b1, "R10 enabled", irq, 1);
        wr(2'd1, 8'h02);
        rd(2'd1, v);
        check(v == 8'h02, "R9 cleared", v, 8'h02);
        check(irq == 1'b0, "R10 cleared", irq, 0);
        tick_on = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        tick_on = 1'b1;
        t_rate();
        t_interval();
        t_lcd();
        t_hold();
        t_priority();
        t_flag();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule